// File: doc/BRIEF.md
# Configurable-Priority Interrupt Arbiter

This block selects one interrupt out of up to 64 that are pending and enabled at a single privilege level. Each interrupt has an 8-bit priority value, and a numerically smaller value is more urgent. If the value is zero, it is replaced by an effective priority derived from a fixed default ranking and from the level's own external-interrupt default. When two pending interrupts have the same effective priority, the higher interrupt number wins. A legacy input turns off the priority values, and the block then returns the lowest pending index.

The surrounding core is responsible for delegation, enable gating and the storage of the priority values. It presents the masked pending vector, the priority array, the number of this level's external interrupt and that interrupt's default priority. The arbiter answers with a winner number and a valid flag. The selection logic is a balanced minimum tree. A parameter chooses whether the result is taken straight from the tree or through an output register, which is enabled by default.

Top module: `irq_prio_arb`

## Requirements
- R1: Among pending interrupts, the one with the numerically smallest effective priority is reported on `win_id_o` with `win_vld_o` high.
- R2: If several pending interrupts share the smallest effective priority, the one with the highest interrupt number is reported.
- R3: A pending interrupt whose priority field is zero and whose number equals `ext_id_i` takes `ext_dflt_i` as its effective priority.
- R4: Any other pending interrupt with a zero priority field takes effective priority 1 when its default rank is numerically below `ext_dflt_i`, and 255 otherwise.
- R5: Default ranks are consecutive from 4 in this order: 63,62,31,30,61,60,59,58,29,28,57,56,55,54,27,26,53,52,51,50,25,24,49,48,11,3,7,9,1,5,12,10,2,6,47,46,23,22,45,44,43,42,21,20,41,40,39,38,19,18,37,36,35,34,17,16,33,32. This gives 63 rank 4, 11 rank 28, 9 rank 31, 12 rank 34, 10 rank 35, 47 rank 38 and 32 rank 61. Numbers that do not appear in the list have rank 255.
- R6: With `legacy_i` high, the priority fields and the external settings are ignored, and the lowest-numbered pending interrupt is reported.
- R7: An all-zero pending vector gives `win_vld_o` low and `win_id_o` zero.
- R8: With the output register enabled, the default case, the result for inputs held across a rising clock edge appears after that edge. While `rst_ni` is low, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| legacy_i | input | 1 | 1 = lowest pending index wins, priorities ignored |
| pend_i | input | 64 | Pending and enabled interrupt vector, bit n = interrupt n |
| prio_i | input | 512 | Priority fields, bits [8n+7:8n] belong to interrupt n |
| ext_id_i | input | 6 | Number of this level's external interrupt |
| ext_dflt_i | input | 8 | Default priority of this level's external interrupt |
| win_vld_o | output | 1 | A pending interrupt was selected |
| win_id_o | output | 6 | Selected interrupt number, zero when none |

## Verification
Ties are the first target. Several interrupts are given the same explicit priority, so a design that kept the first index found would return the lower number. Zero-priority fields are placed on either side of the external default, including one rank exactly equal to it. A design that substituted the raw rank, or that used less-or-equal in the rank comparison, would choose a different winner. Unlisted numbers competing at 255 and the external interrupt tying with an explicit value check the substitution paths. Legacy mode runs with priorities that would otherwise reverse the outcome, which catches a design that still reads them.

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_IRQ = 64,
  parameter int PW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  legacy_i,
  input  logic [NUM_IRQ-1:0]    pend_i,
  input  logic [NUM_IRQ*PW-1:0] prio_i,
  input  logic [$clog2(NUM_IRQ)-1:0] ext_id_i,
  input  logic [PW-1:0]         ext_dflt_i,
  output logic                  win_vld_o,
  output logic [$clog2(NUM_IRQ)-1:0] win_id_o
);
  localparam int IW = $clog2(NUM_IRQ);
  localparam int KW = 1 + PW + IW;
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  function automatic int dflt_rank(int n);
    int d;
    if (n >= 48 && n <= 63) begin
      d = 63 - n;
      return 4 + 6 * (d / 4) + ((d % 4) < 2 ? d % 4 : d % 4 + 2);
    end
    if (n >= 24 && n <= 31) begin
      d = 31 - n;
      return 4 + 6 * (d / 2) + 2 + d % 2;
    end
    if (n >= 32 && n <= 47) begin
      d = 47 - n;
      return 38 + 6 * (d / 4) + ((d % 4) < 2 ? d % 4 : d % 4 + 2);
    end
    if (n >= 16 && n <= 23) begin
      d = 23 - n;
      return 38 + 6 * (d / 2) + 2 + d % 2;
    end
    case (n)
      11: return 28;
      3:  return 29;
      7:  return 30;
      9:  return 31;
      1:  return 32;
      5:  return 33;
      12: return 34;
      10: return 35;
      2:  return 36;
      6:  return 37;
      default: return 255;
    endcase
  endfunction

  logic [KW-1:0] leaf [NUM_IRQ];
  logic [KW-1:0] node [2*NUM_IRQ];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_leaf
    localparam logic [PW-1:0] RANK = PW'(dflt_rank(i));
    logic [PW-1:0] raw, eff;
    assign raw = prio_i[i*PW +: PW];
    always_comb begin
      if (raw != '0)                    eff = raw;
      else if (ext_id_i == IW'(i))      eff = ext_dflt_i;
      else if (RANK < ext_dflt_i)       eff = PW'(1);
      else                              eff = PMAX;
    end
    assign leaf[i] = legacy_i ? {~pend_i[i], {PW{1'b0}}, IW'(i)}
                              : {~pend_i[i], eff, ~IW'(i)};
  end

  always_comb begin
    node[0] = '0;
    for (int i = 0; i < NUM_IRQ; i++) node[NUM_IRQ + i] = leaf[i];
    for (int j = NUM_IRQ - 1; j >= 1; j--)
      node[j] = (node[2*j] <= node[2*j+1]) ? node[2*j] : node[2*j+1];
  end

  logic          nxt_vld;
  logic [IW-1:0] nxt_id;
  assign nxt_vld = ~node[1][KW-1];
  assign nxt_id  = !nxt_vld ? '0 : (legacy_i ? node[1][IW-1:0] : ~node[1][IW-1:0]);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_vld_o <= 1'b0;
        win_id_o  <= '0;
      end else begin
        win_vld_o <= nxt_vld;
        win_id_o  <= nxt_id;
      end
    end

    a_r8_pend_gives_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pend_i) |=> win_vld_o);
    a_r7_idle_gives_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|pend_i) |=> (!win_vld_o && win_id_o == '0));
  end else begin : g_comb
    assign win_vld_o = nxt_vld;
    assign win_id_o  = nxt_id;
  end

  a_r1_winner_is_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_vld |-> pend_i[nxt_id]);
  a_r7_valid_iff_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_vld == (|pend_i));
  a_r6_legacy_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_i && nxt_vld) |-> ((pend_i & ((NUM_IRQ'(1) << nxt_id) - NUM_IRQ'(1))) == '0));
endmodule

// File: tb/irq_prio_arb_test.sv
module irq_prio_arb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic legacy = 1'b0;
  logic [63:0] pend = '0;
  logic [7:0] pr [64];
  logic [511:0] prio_flat;
  logic [5:0] ext_id = 6'd0;
  logic [7:0] ext_dflt = 8'd0;
  logic win_vld;
  logic [5:0] win_id;
  int checks = 0, fails = 0;
  int rk [64];
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_comb for (int n = 0; n < 64; n++) prio_flat[n*8 +: 8] = pr[n];

  irq_prio_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .legacy_i(legacy), .pend_i(pend),
    .prio_i(prio_flat), .ext_id_i(ext_id), .ext_dflt_i(ext_dflt),
    .win_vld_o(win_vld), .win_id_o(win_id)
  );

  function automatic logic [6:0] model();
    int best = -1;
    int bp = 1000;
    int e;
    for (int n = 0; n < 64; n++) begin
      if (pend[n]) begin
        if (legacy) begin
          if (best < 0) best = n;
        end else begin
          if (pr[n] != 0) e = pr[n];
          else if (n == ext_id) e = ext_dflt;
          else e = (rk[n] < ext_dflt) ? 1 : 255;
          if (e <= bp) begin bp = e; best = n; end
        end
      end
    end
    return (best < 0) ? 7'd0 : {1'b1, 6'(best)};
  endfunction

  task automatic check(string tag, logic [6:0] exp);
    checks++;
    if ({win_vld, win_id} !== exp) begin
      fails++;
      $display("FAIL %s: got vld=%0b id=%0d, expected vld=%0b id=%0d",
               tag, win_vld, win_id, exp[6], exp[5:0]);
    end
  endtask

  task automatic clear();
    pend = '0; legacy = 1'b0;
    for (int n = 0; n < 64; n++) pr[n] = 8'd0;
  endtask

  task automatic run(string tag, logic [6:0] exp);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    int order [58] = '{63,62,31,30,61,60,59,58,29,28,57,56,55,54,27,26,53,52,51,50,
                       25,24,49,48,11,3,7,9,1,5,12,10,2,6,47,46,23,22,45,44,43,42,
                       21,20,41,40,39,38,19,18,37,36,35,34,17,16,33,32};
    for (int n = 0; n < 64; n++) rk[n] = 255;
    for (int k = 0; k < 58; k++) rk[order[k]] = 4 + k;
    clear();
    pend = 64'hFFFF;
    repeat (3) @(negedge clk);
    check("R8 reset", 7'd0);
    rst_n = 1'b1;
    clear();

    run("R7 empty", 7'd0);

    pend[17] = 1; pr[17] = 8'd90; pend[40] = 1; pr[40] = 8'd12;
    run("R1 smaller prio wins", {1'b1, 6'd40});

    clear(); pend[3] = 1; pr[3] = 8'd7; pend[40] = 1; pr[40] = 8'd7; pend[20] = 1; pr[20] = 8'd7;
    run("R2 tie to highest", {1'b1, 6'd40});

    clear(); ext_id = 6'd9; ext_dflt = 8'd31;
    pend[9] = 1; pend[5] = 1; pr[5] = 8'd31;
    run("R3 ext default ties", {1'b1, 6'd9});
    pr[5] = 8'd30;
    run("R3 ext default loses", {1'b1, 6'd5});

    clear(); ext_id = 6'd9; ext_dflt = 8'd31;
    pend[11] = 1; pend[1] = 1; pr[1] = 8'd2;
    run("R4 rank below gives 1", {1'b1, 6'd11});

    clear(); ext_id = 6'd11; ext_dflt = 8'd31;
    pend[9] = 1; pend[16] = 1; pr[16] = 8'd200;
    run("R4 rank equal gives 255", {1'b1, 6'd16});

    clear(); ext_dflt = 8'd200; ext_id = 6'd50;
    pend[0] = 1; pend[32] = 1; pr[0] = 8'd0;
    run("R5 rank 61 below 200", {1'b1, 6'd32});
    clear(); pend[0] = 1; pend[13] = 1; pend[14] = 1; pr[14] = 8'd255;
    run("R5 unlisted tie at 255", {1'b1, 6'd14});
    clear(); ext_dflt = 8'd35; pend[12] = 1; pend[10] = 1; pr[63] = 8'd0; pr[10] = 8'd1;
    run("R5 rank 34 vs 35", {1'b1, 6'd12});

    clear(); legacy = 1'b1; pend[5] = 1; pr[5] = 8'd250; pend[60] = 1; pr[60] = 8'd1;
    run("R6 legacy lowest", {1'b1, 6'd5});
    pend[0] = 1; pr[0] = 8'd255;
    run("R6 legacy bit 0", {1'b1, 6'd0});

    clear(); pend = 64'h8000_0000_0000_0000;
    run("R1 single top", {1'b1, 6'd63});
    pend = '0;
    run("R7 empty again", 7'd0);

    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      legacy = ($urandom % 8) == 0;
      pend = {$urandom, $urandom} & {$urandom, $urandom};
      if (t % 5 == 0) pend = pend & {$urandom, $urandom} & {$urandom, $urandom};
      if (t % 23 == 0) pend = '0;
      for (int n = 0; n < 64; n++)
        pr[n] = (($urandom % 3) == 0) ? 8'd0 : 8'($urandom % ((t % 2) ? 8 : 256));
      ext_id = 6'($urandom);
      ext_dflt = (t % 3 == 0) ? 8'd31 : ((t % 3 == 1) ? 8'd28 : 8'($urandom));
      run(legacy ? "R6 random" : "R1/R2/R3/R4/R5 random", model());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule